// File: doc/BRIEF.md
# Memory Reference Alignment Checker

This unit sits beside the load/store pipeline. Each cycle it may receive one data memory reference and classifies it. The reference is described by an address, an operand size code, an access kind, an alignment-check enable, a write-back-cacheable attribute and a configuration bit for unsupported extended references. One cycle later the unit reports whether the reference raises an unaligned-data fault or an unsupported-data fault, and whether it is performed as a single atomic access.

The boundary a reference needs does not always match its operand size. Ten-byte extended operands need 16-byte alignment. Integer/double pairs need 16-byte alignment and single-precision pairs need 8-byte alignment. The 16-byte load/store kind is checked even when the enable bit is off. The memory attribute controls whether an aligned extended reference is atomic, and it can produce an unsupported-data fault.

Top module: `mem_align_check`

## Requirements
- R1: The size code sets the required boundary for a normal access: 0 (1 B) needs 1, 1 (2 B) needs 2, 2 (4 B) needs 4, 3 (8 B) needs 8. Code 4 (10 B extended), code 5 (16 B) and the unused codes 6 and 7 all need 16.
- R2: When the enable input is 1, a reference that is off its required boundary reports fault type 2'b01 (unaligned).
- R3: Access kind 2'b01 (16-byte load/store) needs 16-byte alignment. When it is misaligned it reports fault type 2'b01, whatever the enable input says.
- R4: A reference whose address meets its required boundary never reports fault type 2'b01.
- R5: An aligned normal reference is reported atomic. The one exception is size code 4 when the write-back attribute is 0.
- R6: An aligned normal reference with size code 4, the write-back attribute at 0 and the unsupported-enable input at 1 reports fault type 2'b10 (unsupported). With unsupported-enable at 0 it reports no fault and is not atomic.
- R7: Kind 2'b10 (integer/double pair) needs 16-byte alignment and kind 2'b11 (single pair) needs 8-byte alignment. Each is atomic when aligned. When misaligned, each faults only if the enable input is 1.
- R8: An aligned 16-byte load/store (kind 2'b01) is atomic and raises no fault.
- R9: A misaligned reference of any kind other than 2'b01, with the enable input at 0, raises no fault and has the atomic flag at 0.
- R10: Fault type encoding is 2'b00 none, 2'b01 unaligned, 2'b10 unsupported. The fault-valid output is 1 exactly when the type is not 2'b00. An unaligned fault takes priority over an unsupported fault.
- R11: Outputs are registered and describe the reference presented one cycle earlier. A cycle without a valid input gives zero fault and atomic outputs on the next cycle.
- R12: A synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A reference is presented this cycle |
| inAddr | input | ADDR_W | Reference byte address |
| inSize | input | 3 | Operand size code (see R1) |
| inKind | input | 2 | Access kind: 00 normal, 01 16-byte ld/st, 10 int/double pair, 11 single pair |
| alignChkEn | input | 1 | Alignment-check enable |
| wbAttr | input | 1 | Memory is write-back cacheable |
| unsupEn | input | 1 | Aligned non-write-back extended references raise an unsupported fault |
| outValid | output | 1 | Registered copy of inValid |
| outFaultValid | output | 1 | A fault was raised |
| outFaultType | output | 2 | Fault type (see R10) |
| outAtomic | output | 1 | The reference is performed atomically |

## Verification
The assertions check on every cycle that the outputs follow the input by one cycle, that idle cycles give zero outputs, and that fault-valid agrees with the type. They also check that a fault never comes with the atomic flag, that aligned references never get an unaligned fault, and that misaligned 16-byte load/stores always do. The per-kind and per-size boundary choices, the attribute-driven atomic exception and the effect of the unsupported-enable bit are shown by the bench. Its behavioural model is compared against the outputs on every clock, over directed corner cases and a long pseudo-random stream.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int LOW_BITS = 4;

  typedef enum logic [1:0] {
    KIND_NORMAL      = 2'b00,
    KIND_QUAD        = 2'b01,
    KIND_PAIR_WIDE   = 2'b10,
    KIND_PAIR_SINGLE = 2'b11
  } accKind_e;

  typedef enum logic [1:0] {
    FT_NONE        = 2'b00,
    FT_UNALIGNED   = 2'b01,
    FT_UNSUPPORTED = 2'b10
  } faultType_e;

  // strobes from decode control to the datapath
  typedef struct packed {
    logic [LOW_BITS-1:0] alignMask;   // address bits that must be zero
    logic                forceCheck;  // check regardless of enable bit
    logic                extRef;      // 10-byte extended normal reference
  } refStb_t;
endpackage

// File: rtl/mra_ctrl.sv
module mra_ctrl
  import mra_pkg::*;
(
  input  logic [2:0] inSize,
  input  logic [1:0] inKind,
  output refStb_t    stb
);
  always_comb begin
    stb = '0;
    unique case (accKind_e'(inKind))
      KIND_QUAD: begin
        stb.alignMask  = 4'hF;
        stb.forceCheck = 1'b1;
      end
      KIND_PAIR_WIDE:   stb.alignMask = 4'hF;
      KIND_PAIR_SINGLE: stb.alignMask = 4'h7;
      default: begin
        unique case (inSize)
          3'd0:    stb.alignMask = 4'h0;
          3'd1:    stb.alignMask = 4'h1;
          3'd2:    stb.alignMask = 4'h3;
          3'd3:    stb.alignMask = 4'h7;
          default: stb.alignMask = 4'hF;   // 10 B, 16 B, unused codes
        endcase
        stb.extRef = (inSize == 3'd4);
      end
    endcase
  end
endmodule

// File: rtl/mra_datapath.sv
module mra_datapath
  import mra_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  refStb_t           stb,
  input  logic              alignChkEn,
  input  logic              wbAttr,
  input  logic              unsupEn,
  output logic              outValid,
  output logic              outFaultValid,
  output logic [1:0]        outFaultType,
  output logic              outAtomic
);
  localparam int CHK_BITS = (ADDR_W < LOW_BITS) ? ADDR_W : LOW_BITS;

  logic [LOW_BITS-1:0] lowAddr;
  logic misaligned, unalFault, unsupFault, atomicNext;
  faultType_e typeNext;

  generate
    if (CHK_BITS == LOW_BITS) begin : g_full
      assign lowAddr = inAddr[LOW_BITS-1:0];
    end else begin : g_narrow
      assign lowAddr = {{(LOW_BITS-CHK_BITS){1'b0}}, inAddr[CHK_BITS-1:0]};
    end
  endgenerate

  always_comb begin
    misaligned = |(lowAddr & stb.alignMask);
    unalFault  = misaligned && (alignChkEn || stb.forceCheck);
    unsupFault = !misaligned && stb.extRef && !wbAttr && unsupEn;
    atomicNext = !misaligned && !(stb.extRef && !wbAttr);
    if (unalFault)       typeNext = FT_UNALIGNED;
    else if (unsupFault) typeNext = FT_UNSUPPORTED;
    else                 typeNext = FT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid      <= 1'b0;
      outFaultValid <= 1'b0;
      outFaultType  <= FT_NONE;
      outAtomic     <= 1'b0;
    end else begin
      outValid      <= inValid;
      outFaultValid <= inValid && (typeNext != FT_NONE);
      outFaultType  <= inValid ? typeNext : FT_NONE;
      outAtomic     <= inValid && atomicNext;
    end
  end

  assert_type_agree_R10: assert property (@(posedge clk) disable iff (rst)
    outFaultValid == (outFaultType != 2'b00));
  assert_type_legal_R10: assert property (@(posedge clk) disable iff (rst)
    outFaultType != 2'b11);
  assert_fault_not_atomic_R5: assert property (@(posedge clk) disable iff (rst)
    outFaultValid |-> !outAtomic);
  assert_unsup_needs_nonwb_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && wbAttr) |=> (outFaultType != 2'b10));
endmodule

// File: rtl/mem_align_check.sv
module mem_align_check
  import mra_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [2:0]        inSize,
  input  logic [1:0]        inKind,
  input  logic              alignChkEn,
  input  logic              wbAttr,
  input  logic              unsupEn,
  output logic              outValid,
  output logic              outFaultValid,
  output logic [1:0]        outFaultType,
  output logic              outAtomic
);
  refStb_t stb;

  mra_ctrl u_ctrl (
    .inSize (inSize),
    .inKind (inKind),
    .stb    (stb)
  );

  mra_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .inValid       (inValid),
    .inAddr        (inAddr),
    .stb           (stb),
    .alignChkEn    (alignChkEn),
    .wbAttr        (wbAttr),
    .unsupEn       (unsupEn),
    .outValid      (outValid),
    .outFaultValid (outFaultValid),
    .outFaultType  (outFaultType),
    .outAtomic     (outAtomic)
  );

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outFaultValid && !outAtomic && outFaultType == 2'b00));
  assert_quad_forced_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 2'b01 && inAddr[3:0] != 4'h0) |=> (outFaultType == 2'b01));
  assert_aligned_no_unal_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inAddr[3:0] == 4'h0) |=> (outFaultType != 2'b01));
  assert_quad_aligned_atomic_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && inKind == 2'b01 && inAddr[3:0] == 4'h0) |=> (outAtomic && !outFaultValid));
endmodule

// File: tb/mem_align_check_tb.sv
`timescale 1ns/1ps
module mem_align_check_tb;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [2:0] inSize = '0;
  logic [1:0] inKind = '0;
  logic alignChkEn = 1'b0, wbAttr = 1'b1, unsupEn = 1'b0;
  logic outValid, outFaultValid, outAtomic;
  logic [1:0] outFaultType;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // expectation registered at each edge from the inputs seen there
  logic expValid = 0, expFv = 0, expAt = 0;
  logic [1:0] expFt = 0;
  logic expAligned16 = 0;
  string expTag = "R12";

  always #2 clk = ~clk;

  mem_align_check #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inAddr(inAddr),
    .inSize(inSize), .inKind(inKind), .alignChkEn(alignChkEn),
    .wbAttr(wbAttr), .unsupEn(unsupEn), .outValid(outValid),
    .outFaultValid(outFaultValid), .outFaultType(outFaultType),
    .outAtomic(outAtomic));

  function automatic int needAlign(input logic [1:0] k, input logic [2:0] s);
    if (k == 2'b01 || k == 2'b10) return 16;
    if (k == 2'b11) return 8;
    case (s)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk) begin
    int al;
    bit mis, ext, unal, unsup;
    al = needAlign(inKind, inSize);
    mis = (inAddr % al) != 0;
    ext = (inKind == 2'b00) && (inSize == 3'd4);
    unal = mis && (alignChkEn || inKind == 2'b01);
    unsup = !mis && ext && !wbAttr && unsupEn;
    expAligned16 <= !rst && inValid && (inAddr % 16 == 0);
    if (rst) begin
      expValid <= 0; expFv <= 0; expFt <= 0; expAt <= 0; expTag <= "R12";
    end else if (!inValid) begin
      expValid <= 0; expFv <= 0; expFt <= 0; expAt <= 0; expTag <= "R11";
    end else begin
      expValid <= 1;
      expFt <= unal ? 2'b01 : (unsup ? 2'b10 : 2'b00);
      expFv <= unal || unsup;
      expAt <= !mis && !(ext && !wbAttr);
      if (inKind == 2'b01)            expTag <= mis ? "R3" : "R8";
      else if (inKind != 2'b00)       expTag <= "R7";
      else if (mis && alignChkEn)     expTag <= (inSize >= 3'd4) ? "R1" : "R2";
      else if (mis)                   expTag <= "R9";
      else if (ext && !wbAttr)        expTag <= "R6";
      else                            expTag <= "R5";
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done && cycles > 1) begin
      check(expTag, "outValid", outValid, expValid);
      check(expTag, "outFaultValid", outFaultValid, expFv);
      check(expTag, "outFaultType", outFaultType, expFt);
      check(expTag, "outAtomic", outAtomic, expAt);
      check("R10", "faultValid vs type", outFaultValid, outFaultType != 2'b00);
      if (expAligned16) check("R4", "aligned unal fault", outFaultType == 2'b01, 0);
    end
    if (!done && cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1;
      $finish;
    end
  end

  task automatic drive(input logic v, input logic [ADDR_W-1:0] a, input logic [2:0] s,
                       input logic [1:0] k, input logic en, input logic wb, input logic us);
    @(negedge clk);
    inValid = v; inAddr = a; inSize = s; inKind = k;
    alignChkEn = en; wbAttr = wb; unsupEn = us;
  endtask

  initial begin
    // R12: reset state
    inValid = 1'b1; inAddr = 32'h3; inKind = 2'b01;
    repeat (3) @(negedge clk);
    check("R12", "outFaultValid in reset", outFaultValid, 0);
    check("R12", "outValid in reset", outValid, 0);
    @(negedge clk); rst = 1'b0;
    // R1: size boundaries, enable on
    drive(1, 32'h1002, 3'd1, 2'b00, 1, 1, 0);
    drive(1, 32'h1002, 3'd2, 2'b00, 1, 1, 0);
    drive(1, 32'h1004, 3'd3, 2'b00, 1, 1, 0);
    drive(1, 32'h1008, 3'd4, 2'b00, 1, 1, 0);
    drive(1, 32'h1008, 3'd5, 2'b00, 1, 1, 0);
    drive(1, 32'h1008, 3'd7, 2'b00, 1, 1, 0);
    drive(1, 32'h1003, 3'd0, 2'b00, 1, 1, 0);
    // R3 / R8: 16-byte ld/st with enable off
    drive(1, 32'h2004, 3'd0, 2'b01, 0, 1, 0);
    drive(1, 32'h2010, 3'd0, 2'b01, 0, 0, 0);
    // R7: pairs
    drive(1, 32'h3008, 3'd0, 2'b10, 1, 1, 0);
    drive(1, 32'h3008, 3'd0, 2'b10, 0, 1, 0);
    drive(1, 32'h3008, 3'd0, 2'b11, 1, 1, 0);
    drive(1, 32'h3004, 3'd0, 2'b11, 1, 1, 0);
    // R5 / R6: extended references and attribute
    drive(1, 32'h4010, 3'd4, 2'b00, 1, 0, 1);
    drive(1, 32'h4010, 3'd4, 2'b00, 1, 0, 0);
    drive(1, 32'h4010, 3'd4, 2'b00, 1, 1, 1);
    drive(1, 32'h4018, 3'd3, 2'b00, 0, 0, 1);
    // R10 priority: misaligned extended non-wb with both enables
    drive(1, 32'h4018, 3'd4, 2'b00, 1, 0, 1);
    // R9: misaligned, enable off
    drive(1, 32'h5001, 3'd2, 2'b00, 0, 1, 0);
    drive(1, 32'h5004, 3'd4, 2'b00, 0, 0, 1);
    // R11: idle cycles
    drive(0, 32'h5003, 3'd3, 2'b01, 1, 0, 1);
    drive(0, 32'h0, 3'd0, 2'b00, 0, 1, 0);
    // pseudo-random stream
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] | r[1], {$urandom} & 32'hFFFF_FFF0 | {28'b0, r[5:2]}, r[8:6], r[10:9],
            r[11], r[12], r[13]);
      if (i == 1500) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
      end
    end
    drive(0, 32'h0, 3'd0, 2'b00, 0, 1, 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule